// File: doc/BRIEF.md
# Delayed Consumer Push Scheduler

This block decides when a coherence home node should push freshly written data to the caches that a sharing predictor has named as consumers of a line. When a producer writes a line that has been classified as producer-consumer, the block claims a timer slot for that line and records the predicted consumer set. A fixed number of cycles later it emits a single push event that carries the line and the consumer set. The delay gives the producer time to finish a burst of writes before any copies are refreshed.

In early-push mode, a shared read to a pending line cuts the wait short. The read is answered normally elsewhere, and this block immediately emits the push for the remaining consumers and retires the timer, so no second push follows. If the reader was not in the predicted set, the block also signals that the reader should join the consumer list. In timed-only mode, reads never shorten the wait. The number of slots is small and fixed. A write that finds every slot busy is not tracked, and that line keeps plain invalidation behaviour. Data transfer itself happens outside this block.

The delay (`TRIG_DELAY`, at least 2) and all widths are design-time parameters.

Top module: `upd_trigger_sched`

## Requirements
- R1: While reset is asserted and after reset is released, with no writes presented, `trig_valid` and `add_valid` stay 0 and all slots are idle.
- R2: A write to a line that no busy slot holds claims the lowest-numbered free slot. Exactly TRIG_DELAY cycles after the clock edge that samples the write, `trig_valid` pulses for one cycle, carrying that line and the consumer vector given with the write. `add_valid` stays 0.
- R3: A write to a line that already holds a busy slot restarts its delay and replaces its consumer vector. Only one pulse follows, TRIG_DELAY cycles after the last write.
- R4: With `dyn_mode`=1, a read to a pending line raises the pulse on the very clock edge that samples the read. The pulse carries the stored consumers with the reader's bit (bit index = `rd_core`) cleared, and the slot is freed, so no pulse occurs at the original expiry.
- R5: If that early reader's bit is not set in the stored vector, `add_valid` pulses in the same cycle as the early pulse, with `add_core` equal to the reader. The pushed vector still excludes the reader.
- R6: With `dyn_mode`=0, reads never cause a pulse. A pending line fires only at expiry, with its full stored vector.
- R7: A read to a line whose push has already fired, or to a line that was never tracked, produces no pulse and no add indication, in either mode.
- R8: A write to a new line while all NUM_SLOTS slots are busy is dropped. No pulse ever carries that line, and the lines already tracked fire as normal.
- R9: One pulse is emitted per cycle. An early push takes precedence over an expiring slot. Among expired slots the lowest index fires first, and the others hold and fire in the following cycles.
- R10: When a write and a read to the same pending line arrive in the same cycle, the write wins. The delay restarts and no early push occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dyn_mode | input | 1 | 1 = reads may push early, 0 = timed pushes only |
| wr_valid | input | 1 | Producer write to a producer-consumer line |
| wr_line | input | LINE_W | Line identifier of the write |
| wr_consumers | input | NCORES | Predicted consumer set for the write |
| rd_valid | input | 1 | Shared read request present |
| rd_line | input | LINE_W | Line identifier of the read |
| rd_core | input | CORE_W | Core issuing the read |
| trig_valid | output | 1 | Push event, one cycle |
| trig_line | output | LINE_W | Line to push |
| trig_consumers | output | NCORES | Cores that receive the push |
| add_valid | output | 1 | Early reader must join the consumer list |
| add_core | output | CORE_W | Core to add |

## Verification
The checker enforces, on every cycle, the invariants of the slot table. No two busy slots hold the same line, and no countdown exceeds the delay. At most one slot fires per cycle, and a fired slot is freed unless it is reloaded. An add indication always comes with a push that excludes the added core, and never follows a timed-only cycle. The exact expiry cycle, write-burst restarts, cancellation of the timed push after an early one, dropping of writes when the table is full, and the ordering of deferred expiries can only be shown by the bench's scenarios, which count cycles against each write and read.

// File: rtl/uts_pkg.sv
package uts_pkg;
  // Width of an index into a set of n items (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Counter width able to hold delay-1.
  function automatic int cnt_width(input int delay);
    return (delay > 2) ? $clog2(delay) : 1;
  endfunction
endpackage

// File: rtl/uts_slot.sv
module uts_slot #(
  parameter int LINE_W = 16,
  parameter int NCORES = 8,
  parameter int TRIG_DELAY = 1000,
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LINE_W-1:0] load_line,
  input  logic [NCORES-1:0] load_cons,
  input  logic              clear,
  output logic              busy,
  output logic [LINE_W-1:0] line,
  output logic [NCORES-1:0] cons,
  output logic [CNT_W-1:0]  cnt,
  output logic              due
);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRIG_DELAY - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      line <= '0;
      cons <= '0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      line <= load_line;
      cons <= load_cons;
      cnt  <= CNT_LOAD;
    end else if (clear) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign due = busy && (cnt == '0);
endmodule

// File: rtl/uts_pick.sv
module uts_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/upd_trigger_sched.sv
module upd_trigger_sched #(
  parameter int LINE_W     = 16,
  parameter int NCORES     = 8,
  parameter int NUM_SLOTS  = 4,
  parameter int TRIG_DELAY = 1000,
  localparam int CORE_W    = uts_pkg::idx_width(NCORES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dyn_mode,
  input  logic              wr_valid,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [NCORES-1:0] wr_consumers,
  input  logic              rd_valid,
  input  logic [LINE_W-1:0] rd_line,
  input  logic [CORE_W-1:0] rd_core,
  output logic              trig_valid,
  output logic [LINE_W-1:0] trig_line,
  output logic [NCORES-1:0] trig_consumers,
  output logic              add_valid,
  output logic [CORE_W-1:0] add_core
);
  localparam int CNT_W = uts_pkg::cnt_width(TRIG_DELAY);

  function automatic logic [NCORES-1:0] core_bit(input logic [CORE_W-1:0] c);
    return NCORES'(1) << c;
  endfunction

  function automatic logic [NCORES-1:0] strip_reader(input logic [NCORES-1:0] v,
                                                     input logic [CORE_W-1:0] c);
    return v & ~core_bit(c);
  endfunction

  // Slot table state, brought out for the checker.
  logic [NUM_SLOTS-1:0]             slot_busy;
  logic [NUM_SLOTS-1:0]             slot_due;
  logic [NUM_SLOTS-1:0][LINE_W-1:0] slot_line;
  logic [NUM_SLOTS-1:0][NCORES-1:0] slot_cons;
  logic [NUM_SLOTS-1:0][CNT_W-1:0]  slot_cnt;

  // Named internal events.
  logic [NUM_SLOTS-1:0] wr_hit_vec, rd_hit_vec;
  logic [NUM_SLOTS-1:0] alloc_gnt, load_vec;
  logic [NUM_SLOTS-1:0] early_vec, due_eff, due_gnt, fire_vec;
  logic                 wr_hit_any, free_any, alloc_ok, early_any, due_any;
  logic [LINE_W-1:0]    sel_line;
  logic [NCORES-1:0]    sel_cons, push_cons;
  logic                 reader_new;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      wr_hit_vec[i] = wr_valid && slot_busy[i] && (slot_line[i] == wr_line);
      rd_hit_vec[i] = rd_valid && slot_busy[i] && (slot_line[i] == rd_line);
    end
  end

  assign wr_hit_any = |wr_hit_vec;

  uts_pick #(.N(NUM_SLOTS)) u_alloc_pick (
    .req   (~slot_busy),
    .grant (alloc_gnt),
    .any   (free_any)
  );

  assign alloc_ok = wr_valid && !wr_hit_any && free_any;
  assign load_vec = wr_hit_vec | (alloc_ok ? alloc_gnt : '0);

  // Early push: only in dynamic mode, and a same-cycle write to the line wins.
  assign early_vec = dyn_mode ? (rd_hit_vec & ~wr_hit_vec) : '0;
  assign early_any = |early_vec;

  assign due_eff = slot_due & ~wr_hit_vec;

  uts_pick #(.N(NUM_SLOTS)) u_due_pick (
    .req   (due_eff),
    .grant (due_gnt),
    .any   (due_any)
  );

  assign fire_vec = early_any ? early_vec : due_gnt;

  always_comb begin
    sel_line = '0;
    sel_cons = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (fire_vec[i]) begin
        sel_line = sel_line | slot_line[i];
        sel_cons = sel_cons | slot_cons[i];
      end
    end
  end

  assign push_cons  = early_any ? strip_reader(sel_cons, rd_core) : sel_cons;
  assign reader_new = early_any && ((sel_cons & core_bit(rd_core)) == '0);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    uts_slot #(
      .LINE_W     (LINE_W),
      .NCORES     (NCORES),
      .TRIG_DELAY (TRIG_DELAY),
      .CNT_W      (CNT_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_vec[g]),
      .load_line (wr_line),
      .load_cons (wr_consumers),
      .clear     (fire_vec[g]),
      .busy      (slot_busy[g]),
      .line      (slot_line[g]),
      .cons      (slot_cons[g]),
      .cnt       (slot_cnt[g]),
      .due       (slot_due[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_valid     <= 1'b0;
      trig_line      <= '0;
      trig_consumers <= '0;
      add_valid      <= 1'b0;
      add_core       <= '0;
    end else begin
      trig_valid     <= early_any || due_any;
      trig_line      <= sel_line;
      trig_consumers <= push_cons;
      add_valid      <= reader_new;
      add_core       <= rd_core;
    end
  end
endmodule

// File: rtl/upd_trigger_sched_chk.sv
module upd_trigger_sched_chk #(
  parameter int LINE_W     = 16,
  parameter int NCORES     = 8,
  parameter int NUM_SLOTS  = 4,
  parameter int TRIG_DELAY = 1000,
  parameter int CORE_W     = 3,
  parameter int CNT_W      = 10
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             dyn_mode,
  input logic                             trig_valid,
  input logic [NCORES-1:0]                trig_consumers,
  input logic                             add_valid,
  input logic [CORE_W-1:0]                add_core,
  input logic [NUM_SLOTS-1:0]             slot_busy,
  input logic [NUM_SLOTS-1:0][LINE_W-1:0] slot_line,
  input logic [NUM_SLOTS-1:0][CNT_W-1:0]  slot_cnt,
  input logic [NUM_SLOTS-1:0]             fire_vec,
  input logic [NUM_SLOTS-1:0]             load_vec
);
  function automatic int dup_lines(input logic [NUM_SLOTS-1:0] b,
                                   input logic [NUM_SLOTS-1:0][LINE_W-1:0] l);
    int n = 0;
    for (int i = 0; i < NUM_SLOTS; i++)
      for (int j = i + 1; j < NUM_SLOTS; j++)
        if (b[i] && b[j] && l[i] == l[j]) n++;
    return n;
  endfunction

  // R3: restarts reuse the slot, so a line never sits in two slots
  a_r3_unique_lines: assert property (@(posedge clk) disable iff (!rst_n)
    dup_lines(slot_busy, slot_line) == 0);

  // R9: a single slot fires per cycle
  a_r9_one_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_vec));

  // R5: an add indication comes with a push that leaves the reader out
  a_r5_reader_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    add_valid |-> (trig_valid && ((trig_consumers >> add_core) & NCORES'(1)) == '0));

  // R6: timed-only mode never produces an early push
  a_r6_static_no_add: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dyn_mode) |-> !add_valid);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
    // R2: countdown stays within the configured delay
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(slot_cnt[g]) <= TRIG_DELAY - 1);

    // R4: a fired slot is retired, so it cannot fire again at expiry
    a_r4_fire_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_vec[g] && !load_vec[g]) |=> !slot_busy[g]);
  end
endmodule

bind upd_trigger_sched upd_trigger_sched_chk #(
  .LINE_W     (LINE_W),
  .NCORES     (NCORES),
  .NUM_SLOTS  (NUM_SLOTS),
  .TRIG_DELAY (TRIG_DELAY),
  .CORE_W     (CORE_W),
  .CNT_W      (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dyn_mode       (dyn_mode),
  .trig_valid     (trig_valid),
  .trig_consumers (trig_consumers),
  .add_valid      (add_valid),
  .add_core       (add_core),
  .slot_busy      (slot_busy),
  .slot_line      (slot_line),
  .slot_cnt       (slot_cnt),
  .fire_vec       (fire_vec),
  .load_vec       (load_vec)
);

// File: tb/upd_trigger_sched_test.sv
`timescale 1ns/1ps
module upd_trigger_sched_test;
  localparam int LW = 16;
  localparam int NC = 8;
  localparam int CW = 3;
  localparam int D  = 1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dyn_mode = 1'b0;
  logic          wr_valid = 1'b0;
  logic [LW-1:0] wr_line = '0;
  logic [NC-1:0] wr_consumers = '0;
  logic          rd_valid = 1'b0;
  logic [LW-1:0] rd_line = '0;
  logic [CW-1:0] rd_core = '0;
  logic          trig_valid;
  logic [LW-1:0] trig_line;
  logic [NC-1:0] trig_consumers;
  logic          add_valid;
  logic [CW-1:0] add_core;

  upd_trigger_sched uut (
    .clk(clk), .rst_n(rst_n), .dyn_mode(dyn_mode),
    .wr_valid(wr_valid), .wr_line(wr_line), .wr_consumers(wr_consumers),
    .rd_valid(rd_valid), .rd_line(rd_line), .rd_core(rd_core),
    .trig_valid(trig_valid), .trig_line(trig_line), .trig_consumers(trig_consumers),
    .add_valid(add_valid), .add_core(add_core)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Pulse log, sampled 2 ns after each edge.
  int          np = 0;
  int          p_cyc [16];
  logic [LW-1:0] p_line [16];
  logic [NC-1:0] p_cons [16];
  logic        p_add [16];
  logic [CW-1:0] p_addc [16];
  int          stray_add = 0;

  always @(posedge clk) begin
    #2;
    if (rst_n && add_valid && !trig_valid) stray_add++;
    if (rst_n && trig_valid && np < 16) begin
      p_cyc[np]  = cyc;
      p_line[np] = trig_line;
      p_cons[np] = trig_consumers;
      p_add[np]  = add_valid;
      p_addc[np] = add_core;
      np++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Called at a negedge; returns at the next negedge with the sampling cycle.
  task automatic step(input bit wv, input logic [LW-1:0] wl, input logic [NC-1:0] wc,
                      input bit rv, input logic [LW-1:0] rl, input logic [CW-1:0] rc,
                      output int at);
    wr_valid = wv; wr_line = wl; wr_consumers = wc;
    rd_valid = rv; rd_line = rl; rd_core = rc;
    @(negedge clk);
    at = cyc;
    wr_valid = 1'b0; rd_valid = 1'b0;
  endtask

  task automatic do_wr(input logic [LW-1:0] l, input logic [NC-1:0] c, output int at);
    step(1'b1, l, c, 1'b0, '0, '0, at);
  endtask

  task automatic do_rd(input logic [LW-1:0] l, input logic [CW-1:0] c, output int at);
    step(1'b0, '0, '0, 1'b1, l, c, at);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(trig_valid == 1'b0 && add_valid == 1'b0, "R1", "outputs in reset",
          {trig_valid, add_valid}, 0);
    end
    rst_n = 1'b1;
    np = 0;
    repeat (6) @(negedge clk);
    chk(np == 0 && stray_add == 0, "R1", "idle pulses after reset", np, 0);
  endtask

  task automatic t_static_basic;
    int k;
    dyn_mode = 1'b0; np = 0;
    do_wr(16'h0011, 8'h06, k);
    wait_until(k + D + 4);
    chk(np == 1, "R2", "pulse count", np, 1);
    chk(p_cyc[0] == k + D, "R2", "pulse cycle", p_cyc[0], k + D);
    chk(p_line[0] == 16'h0011 && p_cons[0] == 8'h06, "R2", "line/consumers",
        {p_line[0], p_cons[0]}, {16'h0011, 8'h06});
    chk(p_add[0] == 1'b0, "R2", "no add", p_add[0], 0);
  endtask

  task automatic t_restart;
    int k, k2;
    dyn_mode = 1'b0; np = 0;
    do_wr(16'h0022, 8'h81, k);
    wait_until(k + 299);
    do_wr(16'h0022, 8'h18, k2);
    wait_until(k2 + D + 4);
    chk(np == 1, "R3", "single pulse after burst", np, 1);
    chk(p_cyc[0] == k2 + D, "R3", "restarted expiry", p_cyc[0], k2 + D);
    chk(p_cons[0] == 8'h18, "R3", "replaced consumers", p_cons[0], 8'h18);
  endtask

  task automatic t_early_known;
    int k, g;
    dyn_mode = 1'b1; np = 0;
    do_wr(16'h0033, 8'h62, k);
    wait_until(k + 399);
    do_rd(16'h0033, 3'd5, g);
    wait_until(k + D + 10);
    chk(np == 1, "R4", "no second push at expiry", np, 1);
    chk(p_cyc[0] == g, "R4", "early pulse cycle", p_cyc[0], g);
    chk(p_cons[0] == 8'h42, "R4", "reader removed", p_cons[0], 8'h42);
    chk(p_add[0] == 1'b0, "R4", "known reader not added", p_add[0], 0);
  endtask

  task automatic t_early_new;
    int k, g;
    dyn_mode = 1'b1; np = 0;
    do_wr(16'h0044, 8'h0C, k);
    wait_until(k + 49);
    do_rd(16'h0044, 3'd7, g);
    wait_until(k + D + 5);
    chk(np == 1 && p_cyc[0] == g, "R5", "early pulse", p_cyc[0], g);
    chk(p_cons[0] == 8'h0C, "R5", "push excludes new reader", p_cons[0], 8'h0C);
    chk(p_add[0] == 1'b1 && p_addc[0] == 3'd7, "R5", "add indication",
        {p_add[0], p_addc[0]}, {1'b1, 3'd7});
  endtask

  task automatic t_static_read;
    int k, g;
    dyn_mode = 1'b0; np = 0;
    do_wr(16'h0055, 8'h30, k);
    wait_until(k + 99);
    do_rd(16'h0055, 3'd4, g);
    wait_until(k + D + 4);
    chk(np == 1, "R6", "pulse count", np, 1);
    chk(p_cyc[0] == k + D, "R6", "fires only at expiry", p_cyc[0], k + D);
    chk(p_cons[0] == 8'h30 && p_add[0] == 1'b0, "R6", "full vector, no add",
        {p_cons[0], p_add[0]}, {8'h30, 1'b0});
  endtask

  task automatic t_late_read(input bit mode);
    int k, g;
    dyn_mode = mode; np = 0;
    do_wr(16'h0066, 8'h03, k);
    wait_until(k + D + 1);
    do_rd(16'h0066, 3'd0, g);
    do_rd(16'h0077, 3'd2, g);
    repeat (6) @(negedge clk);
    chk(np == 1 && p_cyc[0] == k + D, "R7", mode ? "late read dyn" : "late read static",
        np, 1);
    chk(stray_add == 0, "R7", "no add on late/untracked read", stray_add, 0);
  endtask

  task automatic t_full;
    int k [5];
    bit seen;
    dyn_mode = 1'b0; np = 0;
    for (int i = 0; i < 5; i++) do_wr(LW'(16'h0081 + i), 8'h01, k[i]);
    wait_until(k[4] + D + 4);
    chk(np == 4, "R8", "only tracked lines fire", np, 4);
    seen = 1'b0;
    for (int i = 0; i < np; i++) if (p_line[i] == 16'h0085) seen = 1'b1;
    chk(!seen, "R8", "dropped line never pushed", seen, 0);
    chk(p_line[3] == 16'h0084 && p_cyc[3] == k[3] + D, "R8", "last tracked line timing",
        p_cyc[3], k[3] + D);
  endtask

  task automatic t_order;
    int ka, kb, kc, g;
    dyn_mode = 1'b1; np = 0;
    do_wr(16'h0091, 8'h01, ka);
    do_wr(16'h0092, 8'h02, kb);
    do_wr(16'h0093, 8'h0C, kc);
    wait_until(ka + D - 1);
    do_rd(16'h0093, 3'd2, g);
    wait_until(ka + D + 6);
    chk(np == 3, "R9", "pulse count", np, 3);
    chk(p_cyc[0] == ka + D && p_line[0] == 16'h0093 && p_cons[0] == 8'h08, "R9",
        "early push wins", p_line[0], 16'h0093);
    chk(p_cyc[1] == ka + D + 1 && p_line[1] == 16'h0091, "R9", "deferred slot 0",
        p_cyc[1], ka + D + 1);
    chk(p_cyc[2] == ka + D + 2 && p_line[2] == 16'h0092, "R9", "slot 1 after slot 0",
        p_cyc[2], ka + D + 2);
  endtask

  task automatic t_write_wins;
    int k, g;
    dyn_mode = 1'b1; np = 0;
    do_wr(16'h00A1, 8'h50, k);
    wait_until(k + 199);
    step(1'b1, 16'h00A1, 8'h50, 1'b1, 16'h00A1, 3'd4, g);
    wait_until(g + D + 4);
    chk(np == 1, "R10", "pulse count", np, 1);
    chk(p_cyc[0] == g + D, "R10", "write restarts, no early push", p_cyc[0], g + D);
    chk(p_cons[0] == 8'h50 && p_add[0] == 1'b0, "R10", "full vector",
        p_cons[0], 8'h50);
  endtask

  initial begin
    t_reset;
    t_static_basic;
    t_restart;
    t_early_known;
    t_early_new;
    t_static_read;
    t_late_read(1'b0);
    t_late_read(1'b1);
    t_full;
    t_order;
    t_write_wins;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule